// File: doc/BRIEF.md
# Element-Group Register Packer

This block takes a short group of narrow vector elements and turns it into one full-width register word. The group may leave part of the register empty, for example three 16-bit elements in a 64-bit register. On a write request the empty upper part is filled according to the element type. Integer groups are sign-extended from the highest used element. Floating-point groups have every empty position set to all ones. On a read request the same used portion is extracted, and everything above it is forced to zero. A per-lane mask shows which element lanes carry data.

Each request is a single-cycle operation. The result is captured in an output register one clock after `in_valid`. A request that is malformed raises an error pulse and leaves the held result untouched. A request is malformed when the element count is zero, when the count is more than the register can hold, or when the width code is reserved.

Top module: `eg_pack`

## Requirements
- R1: Element i occupies bits [i*w +: w] of the word, where w is the element width. For a valid request, bits below used = count*w are copied from `in_data` to `out_word` unchanged, for both read and write.
- R2: On a valid integer write (`in_read`=0, `in_fp`=0) with used < 64, every bit at or above `used` equals `in_data[used-1]`.
- R3: On a valid floating-point write (`in_read`=0, `in_fp`=1) with used < 64, every bit at or above `used` is 1.
- R4: On a valid read (`in_read`=1) with used < 64, every bit at or above `used` is 0, whatever `in_data` and `in_fp` carry there.
- R5: When used equals 64, `out_word` equals `in_data` exactly, for reads, integer writes and floating-point writes.
- R6: For a valid request, `out_lanes[i]` is 1 exactly when i < count. Lanes are counted in element units, and bit 0 is element 0.
- R7: Width code `in_ew` has these values: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = reserved. A request is in error if the code is 3, the count is 0, or the count exceeds 64/w. Such a request sets `out_err` for one cycle, and `out_word` and `out_lanes` keep their previous values.
- R8: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. Without a request, `out_err` is low and `out_word` and `out_lanes` hold their values.
- R9: After reset, `out_valid`, `out_err`, `out_word` and `out_lanes` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_read | input | 1 | 1 = read (extract), 0 = write (pack with padding) |
| in_fp | input | 1 | 1 = floating-point elements, 0 = integer elements |
| in_ew | input | 2 | Element width code (0:8, 1:16, 2:32, 3:reserved) |
| in_cnt | input | 4 | Number of used elements |
| in_data | input | 64 | Element data, element 0 in the lowest bits |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_err | output | 1 | Request was rejected |
| out_word | output | 64 | Packed register word or extracted elements |
| out_lanes | output | 8 | Per-lane valid mask |

## Verification
On every cycle the assertions check the following:
- the handshake timing;
- that rejected and idle cycles leave the held result frozen;
- that the lane mask is a contiguous run from lane 0;
- that the lowest element survives;
- the value of the top bit for each padding mode, checked against the sign bit picked by the fill logic;
- the exact pass-through of a full group.

Only the bench scenarios compare the entire word bit by bit against an independent model. The bench covers every width and count, negative and positive top elements, and padding bits in the input that must not leak into a read. It also covers back-to-back errors followed by valid requests.

// File: rtl/eg_pack_pkg.sv
package eg_pack_pkg;

  typedef enum logic [1:0] {
    EW_8   = 2'd0,
    EW_16  = 2'd1,
    EW_32  = 2'd2,
    EW_RSV = 2'd3
  } ew_code_e;

  // Element width in bits for a width code; 0 marks the reserved code.
  function automatic int ew_bits(ew_code_e code);
    case (code)
      EW_8:    return 8;
      EW_16:   return 16;
      EW_32:   return 32;
      default: return 0;
    endcase
  endfunction

  // How many elements of a given width fit in a register.
  function automatic int lane_cap(int reg_w, int w);
    return (w == 0) ? 0 : reg_w / w;
  endfunction

endpackage

// File: rtl/eg_pack_ctl.sv
module eg_pack_ctl import eg_pack_pkg::*; #(
  parameter int REG_W  = 64,
  parameter int LANES  = 8,
  parameter int CNT_W  = 4,
  parameter int USED_W = 7
) (
  input  logic [1:0]        ew_code,
  input  logic [CNT_W-1:0]  cnt,
  output logic              bad,
  output logic [USED_W-1:0] used,
  output logic [LANES-1:0]  lanes
);

  int w;
  int cap;
  int prod;

  always_comb begin
    w    = ew_bits(ew_code_e'(ew_code));
    cap  = lane_cap(REG_W, w);
    prod = int'(cnt) * w;
    bad  = (w == 0) || (cnt == '0) || (int'(cnt) > cap);
    used = bad ? '0 : USED_W'(prod);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes[i] = !bad && (CNT_W'(i) < cnt);
  end

endmodule

// File: rtl/eg_pack_fill.sv
module eg_pack_fill #(
  parameter int REG_W  = 64,
  parameter int USED_W = 7
) (
  input  logic [REG_W-1:0]  data,
  input  logic [USED_W-1:0] used,
  input  logic              rd,
  input  logic              fp,
  output logic [REG_W-1:0]  word,
  output logic              sign_bit
);

  logic [REG_W-1:0] keep;
  logic [REG_W-1:0] top_sel;
  logic             pad;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    assign keep[b]    = USED_W'(b) < used;
    assign top_sel[b] = used == USED_W'(b + 1);
    assign word[b]    = keep[b] ? data[b] : pad;
  end

  assign sign_bit = |(data & top_sel);
  assign pad      = rd ? 1'b0 : (fp ? 1'b1 : sign_bit);

endmodule

// File: rtl/eg_pack.sv
module eg_pack #(
  parameter int REG_W = 64,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_read,
  input  logic                   in_fp,
  input  logic [1:0]             in_ew,
  input  logic [CNT_W-1:0]       in_cnt,
  input  logic [REG_W-1:0]       in_data,
  output logic                   out_valid,
  output logic                   out_err,
  output logic [REG_W-1:0]       out_word,
  output logic [REG_W/8-1:0]     out_lanes
);

  localparam int LANES  = REG_W / 8;
  localparam int USED_W = $clog2(REG_W + 1);

  logic              req_bad;
  logic [USED_W-1:0] used_bits;
  logic [LANES-1:0]  lane_bits;
  logic [REG_W-1:0]  fill_word;
  logic              top_sign;

  eg_pack_ctl #(
    .REG_W(REG_W), .LANES(LANES), .CNT_W(CNT_W), .USED_W(USED_W)
  ) ctl_i (
    .ew_code(in_ew),
    .cnt    (in_cnt),
    .bad    (req_bad),
    .used   (used_bits),
    .lanes  (lane_bits)
  );

  eg_pack_fill #(
    .REG_W(REG_W), .USED_W(USED_W)
  ) fill_i (
    .data    (in_data),
    .used    (used_bits),
    .rd      (in_read),
    .fp      (in_fp),
    .word    (fill_word),
    .sign_bit(top_sign)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_word  <= '0;
      out_lanes <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid && req_bad;
      if (in_valid && !req_bad) begin
        out_word  <= fill_word;
        out_lanes <= lane_bits;
      end
    end
  end

endmodule

// File: rtl/eg_pack_chk.sv
module eg_pack_chk #(
  parameter int REG_W  = 64,
  parameter int LANES  = 8,
  parameter int USED_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_read,
  input logic              in_fp,
  input logic [REG_W-1:0]  in_data,
  input logic              out_valid,
  input logic              out_err,
  input logic [REG_W-1:0]  out_word,
  input logic [LANES-1:0]  out_lanes,
  input logic              req_bad,
  input logic [USED_W-1:0] used_bits,
  input logic              top_sign
);

  logic full;
  logic good;
  assign full = used_bits == USED_W'(REG_W);
  assign good = in_valid && !req_bad;

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_err && $stable(out_word) && $stable(out_lanes));

  assert_err_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && req_bad |=> out_err && $stable(out_word) && $stable(out_lanes));

  assert_mask_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    good |=> ((out_lanes & (out_lanes + 1'b1)) == '0) && (out_lanes != '0) && !out_err);

  assert_low_elem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    good |=> out_word[7:0] == $past(in_data[7:0]));

  assert_int_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
    good && !in_read && !in_fp && !full |=> out_word[REG_W-1] == $past(top_sign));

  assert_fp_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    good && !in_read && in_fp && !full |=> out_word[REG_W-1]);

  assert_read_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    good && in_read && !full |=> !out_word[REG_W-1]);

  assert_full_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    good && full |=> out_word == $past(in_data));

endmodule

bind eg_pack eg_pack_chk #(
  .REG_W(REG_W), .LANES(LANES), .USED_W(USED_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_read  (in_read),
  .in_fp    (in_fp),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_err  (out_err),
  .out_word (out_word),
  .out_lanes(out_lanes),
  .req_bad  (req_bad),
  .used_bits(used_bits),
  .top_sign (top_sign)
);

// File: tb/eg_pack_tb_top.sv
module eg_pack_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_read = 1'b0;
  logic        in_fp = 1'b0;
  logic [1:0]  in_ew = 2'd0;
  logic [3:0]  in_cnt = 4'd0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_err;
  logic [63:0] out_word;
  logic [7:0]  out_lanes;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] hold_word = '0;
  logic [7:0]  hold_lanes = '0;

  always #5 clk = ~clk;

  eg_pack dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_read(in_read),
    .in_fp(in_fp), .in_ew(in_ew), .in_cnt(in_cnt), .in_data(in_data),
    .out_valid(out_valid), .out_err(out_err), .out_word(out_word),
    .out_lanes(out_lanes)
  );

  function automatic int width_of(logic [1:0] code);
    return (code == 2'd3) ? 0 : (8 << code);
  endfunction

  function automatic bit is_bad(logic [1:0] code, logic [3:0] cnt);
    int w = width_of(code);
    return (w == 0) || (cnt == 0) || (int'(cnt) * w > 64);
  endfunction

  function automatic logic [63:0] model_word(bit rd, bit fp, logic [1:0] code,
                                            logic [3:0] cnt, logic [63:0] d);
    logic [63:0] r;
    int used = int'(cnt) * width_of(code);
    logic s = d[used-1];
    for (int b = 0; b < 64; b++)
      r[b] = (b < used) ? d[b] : (rd ? 1'b0 : (fp ? 1'b1 : s));
    return r;
  endfunction

  function automatic logic [7:0] model_lanes(logic [3:0] cnt);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i < int'(cnt));
    return m;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(string req, bit rd, bit fp, logic [1:0] code,
                     logic [3:0] cnt, logic [63:0] d);
    bit bad = is_bad(code, cnt);
    in_valid = 1'b1; in_read = rd; in_fp = fp; in_ew = code;
    in_cnt = cnt; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    if (!bad) begin
      hold_word  = model_word(rd, fp, code, cnt, d);
      hold_lanes = model_lanes(cnt);
    end
    check({req, " R8 valid"}, 64'(out_valid), 64'd1);
    check({req, " R7 err"}, 64'(out_err), 64'(bad));
    check({req, " R1/R2/R3/R4/R5 word"}, out_word, hold_word);
    check({req, " R6 lanes"}, 64'(out_lanes), 64'(hold_lanes));
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R8 idle valid", 64'(out_valid), 64'd0);
    check("R8 idle err", 64'(out_err), 64'd0);
    check("R8 idle word hold", out_word, hold_word);
    check("R8 idle lanes hold", 64'(out_lanes), 64'(hold_lanes));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R9 reset valid", 64'(out_valid), 64'd0);
    check("R9 reset err", 64'(out_err), 64'd0);
    check("R9 reset word", out_word, 64'd0);
    check("R9 reset lanes", 64'(out_lanes), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: three 16-bit ints, top element negative
    run("R2 int neg", 0, 0, 2'd1, 4'd3, 64'h5555_8000_1234_0001);
    // R2: top element positive, garbage above
    run("R2 int pos", 0, 0, 2'd1, 4'd3, 64'hABCD_7FFF_1234_0001);
    // R3: floating point padding
    run("R3 fp pad", 0, 1, 2'd0, 4'd5, 64'h0000_0012_3456_789A);
    // R4: read ignores upper contents
    run("R4 read", 1, 0, 2'd1, 4'd3, 64'hFFFF_8000_1234_0001);
    run("R4 read fp", 1, 1, 2'd2, 4'd1, 64'hDEAD_BEEF_8765_4321);
    // R5: full groups pass through
    run("R5 full int", 0, 0, 2'd2, 4'd2, 64'h8123_4567_0000_0001);
    run("R5 full fp", 0, 1, 2'd0, 4'd8, 64'h0102_0304_0506_0708);
    run("R5 full rd", 1, 0, 2'd1, 4'd4, 64'hF00D_0000_1111_2222);
    idle_check();
    // R7: error cases keep prior result
    run("R7 zero cnt", 0, 0, 2'd0, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R7 too many", 0, 1, 2'd2, 4'd3, 64'h0);
    run("R7 rsv code", 1, 0, 2'd3, 4'd1, 64'h1);
    idle_check();
    run("R1 one byte", 0, 0, 2'd0, 4'd1, 64'h1234_5678_9ABC_DE80);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] code = 2'($urandom_range(0, 3));
      logic [3:0] cnt;
      logic [63:0] d = {$urandom(), $urandom()};
      if (n % 4 == 0) cnt = 4'($urandom_range(0, 15));
      else if (code == 2'd3) cnt = 4'($urandom_range(1, 8));
      else cnt = 4'($urandom_range(1, 64 / width_of(code)));
      run("R1 rand", 1'($urandom()), 1'($urandom()), code, cnt, d);
      if (n % 7 == 0) idle_check();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule